// File: doc/BRIEF.md
# SDRAM Low-Power Entry and Exit Sequencer

This block sits on the controller side of an SDRAM interface. It moves the memory into and out of its two low-power states when a host asks for it. It drives the clock-enable pin and the four command strobes directly.

For self refresh, it brackets the low-power residency with a burst of auto-refresh commands, one burst before entry and one after exit. The refresh commands in each burst are spaced by a row-cycle count. After clock enable rises, the block holds a fixed exit delay of NOP cycles before the first refresh.

For power down, the block lowers clock enable and holds it there. Clock enable goes high again when the host asks, or when a watchdog tied to the refresh period runs out, whichever comes first. After that, the block holds NOP for the required setup window before it returns to idle.

Each completed entry or exit sequence gives a one-cycle `seq_done` pulse. `seq_busy` marks the cycles in which a sequence is running and new requests are refused. The block decodes all of its outputs from state only: a request changes the pins one cycle after the edge that samples it. The reset is active low and asserts asynchronously. It is assumed to be released synchronously to `clk`. `PD_LIMIT` must be at least 2.

Top module: `sdram_lp_seq`

## Requirements
- R1: While reset is asserted and after its release with no request, the outputs are `cke`=1, NOP pins (`cs_n`=0, `ras_n`=`cas_n`=`we_n`=1), `seq_done`=0 and `seq_busy`=0.
- R2: A self-refresh entry request in idle is taken only when `banks_idle` is 1. Otherwise it is ignored, and the pins stay at NOP with `cke`=1.
- R3: An accepted self-refresh request starts, one cycle later, a burst of `BURST_LEN` auto-refresh commands (`cke`=1, `cs_n`=`ras_n`=`cas_n`=0, `we_n`=1). The first one comes at once, and each later one exactly `T_RC` cycles after the one before.
- R4: `T_RC` cycles after the last refresh of the entry burst, the self-refresh command is driven: the same four strobes, with `cke`=0. `seq_done` pulses in that same cycle.
- R5: During self-refresh residency, `cke` stays 0 and the pins show NOP until an exit request arrives.
- R6: `cke` rises in the cycle after the self-refresh exit request. Exactly `T_AC`+`T_XSR` NOP cycles with `cke`=1 follow before the first refresh of the exit burst.
- R7: The exit burst issues `BURST_LEN` refreshes spaced `T_RC` apart. `T_RC` cycles after the last one, `seq_done` pulses on a NOP cycle, and the block returns to idle the next cycle.
- R8: A power-down request in idle drives `cke` to 0 in the next cycle with NOP pins, and `seq_done` pulses in that cycle.
- R9: A power-down exit request raises `cke` in the next cycle. NOP is then held for `T_CKS`+`T_CK` cycles, `seq_done` pulses on the last of them, and the block returns to idle.
- R10: With no exit request, power down ends by itself after exactly `PD_LIMIT` cycles with `cke`=0. The exit then follows the same sequence as R9.
- R11: Every cycle that carries no refresh or self-refresh command shows NOP pins. Requests made while `seq_busy` is 1, or during a low-power residency, have no effect.
- R12: When both entry requests arrive together in idle and `banks_idle` is 1, self refresh is chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| sr_enter_req | input | 1 | Host asks for self-refresh entry |
| sr_exit_req | input | 1 | Host asks for self-refresh exit |
| pd_enter_req | input | 1 | Host asks for power-down entry |
| pd_exit_req | input | 1 | Host asks for power-down exit |
| banks_idle | input | 1 | All banks are precharged |
| cke | output | 1 | SDRAM clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| seq_done | output | 1 | One-cycle pulse when an entry or exit sequence ends |
| seq_busy | output | 1 | A sequence is in progress and requests are refused |

## Verification
The properties take for granted that reset starts low at time zero, so the state is known before the first edge. They also assume that `banks_idle` is only read in idle, since its value in any other cycle has no effect. The refresh-gap property only measures distance between strobe patterns. It therefore depends on the host never driving the pins through any other path. The stimulus changes requests only on falling edges and holds each for one cycle. It asserts entry requests in idle, during bursts and during residency, and it never asserts a self-refresh exit during power down or the reverse.

// File: rtl/lp_pkg.sv
package lp_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_REF = 2'd1,
    CMD_SRE = 2'd2
  } lp_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_PRE_REF  = 3'd1,
    ST_SR_RES   = 3'd2,
    ST_SR_XWAIT = 3'd3,
    ST_POST_REF = 3'd4,
    ST_PD_ENTER = 3'd5,
    ST_PD_RES   = 3'd6,
    ST_PD_XWAIT = 3'd7
  } lp_state_e;
endpackage

// File: rtl/lp_down_timer.sv
module lp_down_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) cnt_d = load_val;
    else if (dec && (cnt_q != '0)) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (load || dec) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/lp_burst_count.sv
module lp_burst_count #(
  parameter int unsigned LIMIT = 4096,
  localparam int unsigned W = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (inc) cnt_q <= cnt_q + 1'b1;
  end

  assign last = (cnt_q == W'(LIMIT));
endmodule

// File: rtl/lp_pin_encode.sv
module lp_pin_encode
  import lp_pkg::*;
(
  input  lp_cmd_e cmd,
  output logic    cs_n,
  output logic    ras_n,
  output logic    cas_n,
  output logic    we_n
);
  always_comb begin
    cs_n  = 1'b0;
    ras_n = 1'b1;
    cas_n = 1'b1;
    we_n  = 1'b1;
    case (cmd)
      CMD_REF, CMD_SRE: begin
        ras_n = 1'b0;
        cas_n = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sdram_lp_seq.sv
module sdram_lp_seq
  import lp_pkg::*;
#(
  parameter int unsigned BURST_LEN = 4096,
  parameter int unsigned T_RC      = 8,
  parameter int unsigned T_AC      = 2,
  parameter int unsigned T_XSR     = 10,
  parameter int unsigned T_CKS     = 2,
  parameter int unsigned T_CK      = 1,
  parameter int unsigned PD_LIMIT  = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sr_enter_req,
  input  logic sr_exit_req,
  input  logic pd_enter_req,
  input  logic pd_exit_req,
  input  logic banks_idle,
  output logic cke,
  output logic cs_n,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic seq_done,
  output logic seq_busy
);
  localparam int unsigned SRX_CYC = T_AC + T_XSR;
  localparam int unsigned PDX_CYC = T_CKS + T_CK;
  localparam int unsigned MAX_A   = (T_RC > SRX_CYC) ? T_RC : SRX_CYC;
  localparam int unsigned MAX_B   = (PD_LIMIT > PDX_CYC) ? PD_LIMIT : PDX_CYC;
  localparam int unsigned TMAX    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned TW      = $clog2(TMAX + 1);
  localparam logic [TW-1:0] RC_M1  = TW'(T_RC - 1);
  localparam logic [TW-1:0] SRX_M1 = TW'(SRX_CYC - 1);
  localparam logic [TW-1:0] PDX_M1 = TW'(PDX_CYC - 1);
  localparam logic [TW-1:0] PDL_M1 = TW'(PD_LIMIT - 1);

  lp_state_e       st_q, st_d;
  lp_cmd_e         cmd;
  logic            t_load, t_dec, t_zero;
  logic [TW-1:0]   t_val;
  logic            b_clr, b_inc, b_last;

  lp_down_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val),
    .dec(t_dec), .zero(t_zero)
  );

  lp_burst_count #(.LIMIT(BURST_LEN)) u_burst (
    .clk(clk), .rst_n(rst_n), .clr(b_clr), .inc(b_inc), .last(b_last)
  );

  lp_pin_encode u_pins (
    .cmd(cmd), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
  );

  always_comb begin
    st_d     = st_q;
    cmd      = CMD_NOP;
    cke      = 1'b1;
    seq_done = 1'b0;
    t_load   = 1'b0;
    t_val    = '0;
    t_dec    = 1'b0;
    b_clr    = 1'b0;
    b_inc    = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (sr_enter_req && banks_idle) begin
          st_d   = ST_PRE_REF;
          t_load = 1'b1;
          b_clr  = 1'b1;
        end else if (pd_enter_req) begin
          st_d   = ST_PD_ENTER;
          t_load = 1'b1;
          t_val  = PDL_M1;
        end
      end
      ST_PRE_REF, ST_POST_REF: begin
        if (!t_zero) begin
          t_dec = 1'b1;
        end else if (b_last) begin
          seq_done = 1'b1;
          if (st_q == ST_PRE_REF) begin
            cmd  = CMD_SRE;
            cke  = 1'b0;
            st_d = ST_SR_RES;
          end else begin
            st_d = ST_IDLE;
          end
        end else begin
          cmd    = CMD_REF;
          b_inc  = 1'b1;
          t_load = 1'b1;
          t_val  = RC_M1;
        end
      end
      ST_SR_RES: begin
        cke = 1'b0;
        if (sr_exit_req) begin
          st_d   = ST_SR_XWAIT;
          t_load = 1'b1;
          t_val  = SRX_M1;
        end
      end
      ST_SR_XWAIT: begin
        if (t_zero) begin
          st_d  = ST_POST_REF;
          b_clr = 1'b1;
        end else begin
          t_dec = 1'b1;
        end
      end
      ST_PD_ENTER: begin
        cke      = 1'b0;
        seq_done = 1'b1;
        t_dec    = 1'b1;
        st_d     = ST_PD_RES;
      end
      ST_PD_RES: begin
        cke = 1'b0;
        if (pd_exit_req || t_zero) begin
          st_d   = ST_PD_XWAIT;
          t_load = 1'b1;
          t_val  = PDX_M1;
        end else begin
          t_dec = 1'b1;
        end
      end
      ST_PD_XWAIT: begin
        if (t_zero) begin
          seq_done = 1'b1;
          st_d     = ST_IDLE;
        end else begin
          t_dec = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign seq_busy = (st_q == ST_PRE_REF) || (st_q == ST_SR_XWAIT) ||
                    (st_q == ST_POST_REF) || (st_q == ST_PD_ENTER) ||
                    (st_q == ST_PD_XWAIT);
endmodule

// File: rtl/sdram_lp_seq_chk.sv
module sdram_lp_seq_chk #(
  parameter int unsigned T_RC     = 8,
  parameter int unsigned PD_LIMIT = 1000
) (
  input logic clk,
  input logic rst_n,
  input logic sr_enter_req,
  input logic pd_enter_req,
  input logic banks_idle,
  input logic cke,
  input logic cs_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic seq_done,
  input logic seq_busy
);
  localparam int unsigned GW = $clog2(T_RC + 1);
  localparam int unsigned LW = $clog2(PD_LIMIT + 2);

  logic          ref_like, nop_pins;
  logic [GW-1:0] gap_q;
  logic          seen_q;
  logic [LW-1:0] low_q;
  logic          sr_mode_q;

  assign ref_like = !cs_n && !ras_n && !cas_n && we_n;
  assign nop_pins = !cs_n && ras_n && cas_n && we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (ref_like) begin
      gap_q  <= GW'(1);
      seen_q <= 1'b1;
    end else if (gap_q < GW'(T_RC)) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q     <= '0;
      sr_mode_q <= 1'b0;
    end else begin
      if (cke) low_q <= '0;
      else if (low_q <= LW'(PD_LIMIT)) low_q <= low_q + 1'b1;
      if (cke) sr_mode_q <= 1'b0;
      else if (ref_like) sr_mode_q <= 1'b1;
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |-> (cke && nop_pins && !seq_busy && !seq_done));

  p_sr_needs_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_busy && cke && sr_enter_req && !banks_idle && !pd_enter_req)
    |=> (cke && nop_pins));

  p_ref_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_like && seen_q) |-> (gap_q >= GW'(T_RC)));

  p_sre_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_like && !cke) |-> seq_done);

  p_rise_nop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> nop_pins);

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_done);

  p_pd_limit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke && !sr_mode_q && !ref_like) |-> (low_q < LW'(PD_LIMIT)));
endmodule

bind sdram_lp_seq sdram_lp_seq_chk #(.T_RC(T_RC), .PD_LIMIT(PD_LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .sr_enter_req(sr_enter_req),
  .pd_enter_req(pd_enter_req), .banks_idle(banks_idle), .cke(cke),
  .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .seq_done(seq_done), .seq_busy(seq_busy)
);

// File: tb/sdram_lp_seq_bench.sv
module sdram_lp_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BL   = 3;
  localparam int TRC  = 4;
  localparam int TAC  = 2;
  localparam int TXSR = 3;
  localparam int TCKS = 1;
  localparam int TCK  = 1;
  localparam int PDL  = 10;
  localparam int SRX  = TAC + TXSR;
  localparam int PDX  = TCKS + TCK;

  localparam logic [4:0] P_NOP_HI = 5'b10111;
  localparam logic [4:0] P_NOP_LO = 5'b00111;
  localparam logic [4:0] P_REF    = 5'b10001;
  localparam logic [4:0] P_SRE    = 5'b00001;

  logic clk = 1'b0;
  logic rst_n;
  logic sr_enter_req, sr_exit_req, pd_enter_req, pd_exit_req, banks_idle;
  logic cke, cs_n, ras_n, cas_n, we_n, seq_done, seq_busy;
  int   n_checks = 0;
  int   n_errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_lp_seq #(
    .BURST_LEN(BL), .T_RC(TRC), .T_AC(TAC), .T_XSR(TXSR),
    .T_CKS(TCKS), .T_CK(TCK), .PD_LIMIT(PDL)
  ) u_sdram_lp_seq (
    .clk(clk), .rst_n(rst_n), .sr_enter_req(sr_enter_req),
    .sr_exit_req(sr_exit_req), .pd_enter_req(pd_enter_req),
    .pd_exit_req(pd_exit_req), .banks_idle(banks_idle), .cke(cke),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .seq_done(seq_done), .seq_busy(seq_busy)
  );

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
  endtask

  // Compare the current outputs, then move to the next falling edge.
  task automatic expect_cyc(input string tag, input logic [4:0] pins,
                            input logic done, input logic busy);
    logic [6:0] act, exp;
    act = {cke, cs_n, ras_n, cas_n, we_n, seq_done, seq_busy};
    exp = {pins, done, busy};
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s at %0t: actual pins/done/busy=%b expected=%b",
               tag, $time, act, exp);
    end
    @(negedge clk);
  endtask

  task automatic t_reset_r1();
    expect_cyc("R1 during reset", P_NOP_HI, 1'b0, 1'b0);
    rst_n = 1'b1;
    expect_cyc("R1 after release", P_NOP_HI, 1'b0, 1'b0);
    expect_cyc("R1 idle hold", P_NOP_HI, 1'b0, 1'b0);
  endtask

  task automatic t_sr_refused_r2();
    banks_idle   = 1'b0;
    sr_enter_req = 1'b1;
    expect_cyc("R2 request cycle", P_NOP_HI, 1'b0, 1'b0);
    sr_enter_req = 1'b0;
    sr_exit_req  = 1'b1;
    expect_cyc("R2 refused without idle banks", P_NOP_HI, 1'b0, 1'b0);
    sr_exit_req = 1'b0;
    expect_cyc("R11 stray exit in idle ignored", P_NOP_HI, 1'b0, 1'b0);
  endtask

  task automatic t_sr_cycle(input bit both_r12);
    banks_idle   = 1'b1;
    sr_enter_req = 1'b1;
    pd_enter_req = both_r12;
    expect_cyc("R12 request cycle", P_NOP_HI, 1'b0, 1'b0);
    sr_enter_req = 1'b0;
    pd_enter_req = 1'b0;
    for (int i = 0; i <= BL*TRC; i++) begin
      if (i == 1) pd_enter_req = 1'b1;
      if (i == 2) begin pd_enter_req = 1'b0; sr_enter_req = 1'b1; end
      if (i == 3) sr_enter_req = 1'b0;
      if (i == BL*TRC)
        expect_cyc("R4 self-refresh command", P_SRE, 1'b1, 1'b1);
      else if (i % TRC == 0)
        expect_cyc(both_r12 ? "R12 R3 entry refresh" : "R3 entry refresh", P_REF, 1'b0, 1'b1);
      else
        expect_cyc("R11 R3 gap NOP", P_NOP_HI, 1'b0, 1'b1);
    end
    for (int i = 0; i < 6; i++) begin
      pd_enter_req = (i == 1);
      sr_enter_req = (i == 2);
      expect_cyc("R5 R11 self-refresh residency", P_NOP_LO, 1'b0, 1'b0);
    end
    pd_enter_req = 1'b0;
    sr_enter_req = 1'b0;
    sr_exit_req  = 1'b1;
    expect_cyc("R5 exit request cycle", P_NOP_LO, 1'b0, 1'b0);
    sr_exit_req = 1'b0;
    for (int i = 0; i <= SRX + BL*TRC; i++) begin
      if (i < SRX)
        expect_cyc("R6 exit delay NOP", P_NOP_HI, 1'b0, 1'b1);
      else if (i - SRX == BL*TRC)
        expect_cyc("R7 exit done", P_NOP_HI, 1'b1, 1'b1);
      else if ((i - SRX) % TRC == 0)
        expect_cyc("R7 exit refresh", P_REF, 1'b0, 1'b1);
      else
        expect_cyc("R7 gap NOP", P_NOP_HI, 1'b0, 1'b1);
    end
    expect_cyc("R7 back to idle", P_NOP_HI, 1'b0, 1'b0);
  endtask

  task automatic t_pd_manual_r9();
    pd_enter_req = 1'b1;
    expect_cyc("R8 request cycle", P_NOP_HI, 1'b0, 1'b0);
    pd_enter_req = 1'b0;
    expect_cyc("R8 power-down entry", P_NOP_LO, 1'b1, 1'b1);
    expect_cyc("R8 power-down residency", P_NOP_LO, 1'b0, 1'b0);
    expect_cyc("R8 power-down residency", P_NOP_LO, 1'b0, 1'b0);
    pd_exit_req = 1'b1;
    expect_cyc("R9 exit request cycle", P_NOP_LO, 1'b0, 1'b0);
    pd_exit_req = 1'b0;
    for (int i = 0; i < PDX; i++)
      expect_cyc("R9 exit hold NOP", P_NOP_HI, (i == PDX-1), 1'b1);
    expect_cyc("R9 back to idle", P_NOP_HI, 1'b0, 1'b0);
  endtask

  task automatic t_pd_watchdog_r10();
    pd_enter_req = 1'b1;
    expect_cyc("R10 request cycle", P_NOP_HI, 1'b0, 1'b0);
    pd_enter_req = 1'b0;
    for (int i = 0; i < PDL; i++)
      expect_cyc("R10 clock enable low window", P_NOP_LO, (i == 0), (i == 0));
    for (int i = 0; i < PDX; i++)
      expect_cyc("R10 forced exit NOP", P_NOP_HI, (i == PDX-1), 1'b1);
    expect_cyc("R10 back to idle", P_NOP_HI, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: run did not end, actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n        = 1'b0;
    sr_enter_req = 1'b0;
    sr_exit_req  = 1'b0;
    pd_enter_req = 1'b0;
    pd_exit_req  = 1'b0;
    banks_idle   = 1'b0;
    @(negedge clk);
    t_reset_r1();
    t_sr_refused_r2();
    t_sr_cycle(1'b0);
    t_pd_manual_r9();
    t_sr_cycle(1'b1);
    t_pd_watchdog_r10();
    summary();
    $finish;
  end
endmodule